// File: doc/BRIEF.md
# E1 Timeslot-Zero Framing Inserter

This block forms the transmit-side E1 frame one bit per clock. Internal counters track the bit within a timeslot, the timeslot within the frame, and whether the frame is even or odd. Whenever the counters point into timeslot 0, the block drives its own framing word onto the line. In every other timeslot it passes the serial payload input straight through.

Timeslot 0 uses two words in turn. An alignment frame sends the international bit first and then the fixed 7-bit alignment pattern. A non-alignment frame sends the international bit, then a constant 1 that prevents the pattern from being imitated, then the remote-alarm bit, then five national bits. A frame-start strobe and the current timeslot number let the payload source keep in step with the frame.

The control inputs (international bit, remote alarm, national bits) are sampled once per frame, on the last bit of the frame. That keeps the timeslot-0 word stable while it is being sent. A build option can make the word follow the control inputs live instead.

Top module: `e1_ts0_framer`

## Requirements
- R1: `slot_idx` counts from 0 to 31. It advances by one every 8 clocks and wraps from 31 to 0.
- R2: `frame_start` is 1 only during the first bit of timeslot 0 and is 0 on every other bit.
- R3: In an alignment frame, bits 2 to 8 of timeslot 0 are 0,0,1,1,0,1,1 in that order. Bit 1 goes out first and each word is sent MSB-first.
- R4: Bit 1 of timeslot 0 carries the international bit in every frame.
- R5: Bit 2 of timeslot 0 in a non-alignment frame is always 1.
- R6: Bit 3 of timeslot 0 in a non-alignment frame carries the remote-alarm input.
- R7: Bits 4 to 8 of timeslot 0 in a non-alignment frame carry `nat_bits[4]` down to `nat_bits[0]`, in that order.
- R8: In every timeslot except 0, including timeslot 16, `line_dout` equals `pay_din` in the same clock.
- R9: The first frame after reset is an alignment frame. Alignment and non-alignment frames then alternate.
- R10: The control inputs are sampled on the last bit of timeslot 31 and used for the next frame. Changes at any other time have no effect on the word being sent. For frame 0 after reset the word uses idle values: international bit = 1, alarm = 0, national bits = 11111.
- R11: `rst` is synchronous and active high. While it is held, the position stays at bit 1 of timeslot 0 of an alignment frame, so `frame_start` = 1 and `slot_idx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pay_din | input | 1 | Serial payload for timeslots 1 to 31 |
| remote_alarm | input | 1 | Remote-alarm request for non-alignment frames |
| nat_bits | input | 5 | National bits for non-alignment frames |
| intl_bit | input | 1 | International bit, bit 1 of timeslot 0 |
| line_dout | output | 1 | Serial line data |
| frame_start | output | 1 | High on the first bit of timeslot 0 |
| slot_idx | output | 5 | Current timeslot number |

## Verification
The bound checker keeps its own position counters. On every cycle it checks the strobe position, the timeslot number, the alignment pattern bits, the forced 1 in non-alignment frames and the payload pass-through. Those checks cover the even/odd alternation from reset onward. The bench's scenarios show what the checker cannot judge alone: that each control value lands in the right bit of the right frame, that control changes during timeslot 0 are ignored, and that a reset in the middle of a frame restarts on an alignment frame using the idle control values.

// File: rtl/e1_fr_pkg.sv
package e1_fr_pkg;
   localparam int            E1_NAT_W   = 5;
   localparam logic [6:0]    E1_FAS_DEF = 7'b0011011;

   typedef struct packed {
      logic                intl;
      logic                alarm;
      logic [E1_NAT_W-1:0] nat;
   } ts0_ctrl_t;

   localparam ts0_ctrl_t E1_CTRL_IDLE = '{intl: 1'b1, alarm: 1'b0, nat: '1};
endpackage

// File: rtl/e1_fr_timer.sv
module e1_fr_timer #(
   parameter  int SLOTS  = 32,
   parameter  int BITS   = 8,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int BIT_W  = $clog2(BITS)
) (
   input  logic              clk,
   input  logic              rst,
   output logic [BIT_W-1:0]  bit_pos,
   output logic [SLOT_W-1:0] slot,
   output logic              odd,
   output logic              frame_end
);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   logic last_bit;
   logic last_slot;

   assign last_bit  = (bit_pos == LAST_BIT);
   assign last_slot = (slot == LAST_SLOT);
   assign frame_end = last_bit & last_slot;

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_pos <= '0;
         slot    <= '0;
         odd     <= 1'b0;
      end else begin
         bit_pos <= last_bit ? '0 : bit_pos + 1'b1;
         if (last_bit) begin
            slot <= last_slot ? '0 : slot + 1'b1;
         end
         if (frame_end) begin
            odd <= ~odd;
         end
      end
   end
endmodule

// File: rtl/e1_fr_ctrl.sv
module e1_fr_ctrl
   import e1_fr_pkg::*;
#(
   parameter bit SAMPLE_AT_END = 1'b1
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      frame_end,
   input  ts0_ctrl_t ctrl_in,
   output ts0_ctrl_t ctrl_out
);
   generate
      if (SAMPLE_AT_END) begin : g_held
         ts0_ctrl_t held;
         always_ff @(posedge clk) begin
            if (rst) begin
               held <= E1_CTRL_IDLE;
            end else if (frame_end) begin
               held <= ctrl_in;
            end
         end
         assign ctrl_out = held;
      end else begin : g_live
         logic unused_ok;
         assign unused_ok = clk ^ rst ^ frame_end;
         assign ctrl_out  = ctrl_in;
      end
   endgenerate
endmodule

// File: rtl/e1_fr_word.sv
module e1_fr_word
   import e1_fr_pkg::*;
#(
   parameter  int         BITS  = 8,
   parameter  logic [6:0] FAS   = E1_FAS_DEF,
   localparam int         BIT_W = $clog2(BITS)
) (
   input  logic             odd,
   input  ts0_ctrl_t        ctrl,
   input  logic [BIT_W-1:0] bit_pos,
   output logic             word_bit
);
   localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(BITS - 1);

   logic [BITS-1:0]  word;
   logic [BIT_W-1:0] sel;

   always_comb begin
      if (odd) begin
         word = {ctrl.intl, 1'b1, ctrl.alarm, ctrl.nat};
      end else begin
         word = {ctrl.intl, FAS};
      end
   end

   assign sel      = TOP_IDX - bit_pos;
   assign word_bit = word[sel];
endmodule

// File: rtl/e1_ts0_framer.sv
module e1_ts0_framer
   import e1_fr_pkg::*;
#(
   parameter  int         SLOTS_PER_FRAME = 32,
   parameter  int         BITS_PER_SLOT   = 8,
   parameter  logic [6:0] FAS_WORD        = E1_FAS_DEF,
   parameter  bit         CTRL_AT_END     = 1'b1,
   localparam int         SLOT_W          = $clog2(SLOTS_PER_FRAME),
   localparam int         BIT_W           = $clog2(BITS_PER_SLOT)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pay_din,
   input  logic              remote_alarm,
   input  logic [4:0]        nat_bits,
   input  logic              intl_bit,
   output logic              line_dout,
   output logic              frame_start,
   output logic [SLOT_W-1:0] slot_idx
);
   initial begin : param_chk
      if (BITS_PER_SLOT != 8)   $error("timeslot must hold 8 bits");
      if (SLOTS_PER_FRAME < 2)  $error("frame needs at least two timeslots");
   end

   logic [BIT_W-1:0]  bit_pos;
   logic [SLOT_W-1:0] slot;
   logic              odd;
   logic              frame_end;
   ts0_ctrl_t         ctrl_in;
   ts0_ctrl_t         ctrl_use;
   logic              word_bit;

   e1_fr_timer #(.SLOTS(SLOTS_PER_FRAME), .BITS(BITS_PER_SLOT)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .bit_pos   (bit_pos),
      .slot      (slot),
      .odd       (odd),
      .frame_end (frame_end)
   );

   assign ctrl_in = '{intl: intl_bit, alarm: remote_alarm, nat: nat_bits};

   e1_fr_ctrl #(.SAMPLE_AT_END(CTRL_AT_END)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .frame_end (frame_end),
      .ctrl_in   (ctrl_in),
      .ctrl_out  (ctrl_use)
   );

   e1_fr_word #(.BITS(BITS_PER_SLOT), .FAS(FAS_WORD)) u_word (
      .odd      (odd),
      .ctrl     (ctrl_use),
      .bit_pos  (bit_pos),
      .word_bit (word_bit)
   );

   assign line_dout   = (slot == '0) ? word_bit : pay_din;
   assign frame_start = (slot == '0) && (bit_pos == '0);
   assign slot_idx    = slot;
endmodule

// File: rtl/e1_ts0_framer_chk.sv
module e1_ts0_framer_chk #(
   parameter int         SLOTS  = 32,
   parameter int         BITS   = 8,
   parameter logic [6:0] FAS    = 7'b0011011,
   parameter int         SLOT_W = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              pay_din,
   input logic              line_dout,
   input logic              frame_start,
   input logic [SLOT_W-1:0] slot_idx
);
   int   c_bit;
   int   c_slot;
   logic c_odd;

   always_ff @(posedge clk) begin
      if (rst) begin
         c_bit  <= 0;
         c_slot <= 0;
         c_odd  <= 1'b0;
      end else if (c_bit == BITS - 1) begin
         c_bit <= 0;
         if (c_slot == SLOTS - 1) begin
            c_slot <= 0;
            c_odd  <= ~c_odd;
         end else begin
            c_slot <= c_slot + 1;
         end
      end else begin
         c_bit <= c_bit + 1;
      end
   end

   // R2
   strobe_pos_chk: assert property (@(posedge clk) disable iff (rst)
      frame_start == (c_slot == 0 && c_bit == 0));

   // R1
   slot_track_chk: assert property (@(posedge clk) disable iff (rst)
      int'(slot_idx) == c_slot);

   // R3 R9
   fas_bits_chk: assert property (@(posedge clk) disable iff (rst)
      (c_slot == 0 && !c_odd && c_bit != 0) |-> line_dout == FAS[BITS-1-c_bit]);

   // R5
   anti_imit_chk: assert property (@(posedge clk) disable iff (rst)
      (c_slot == 0 && c_odd && c_bit == 1) |-> line_dout);

   // R8
   payload_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (c_slot != 0) |-> line_dout == pay_din);

   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> !frame_start);
endmodule

bind e1_ts0_framer e1_ts0_framer_chk #(
   .SLOTS (SLOTS_PER_FRAME),
   .BITS  (BITS_PER_SLOT),
   .FAS   (FAS_WORD),
   .SLOT_W(SLOT_W)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .pay_din     (pay_din),
   .line_dout   (line_dout),
   .frame_start (frame_start),
   .slot_idx    (slot_idx)
);

// File: tb/e1_ts0_framer_test.sv
module e1_ts0_framer_test;
   logic       clk = 1'b0;
   logic       rst;
   logic       pay_din;
   logic       remote_alarm;
   logic [4:0] nat_bits;
   logic       intl_bit;
   logic       line_dout;
   logic       frame_start;
   logic [4:0] slot_idx;

   always #4 clk = ~clk;

   e1_ts0_framer uut (
      .clk(clk), .rst(rst), .pay_din(pay_din), .remote_alarm(remote_alarm),
      .nat_bits(nat_bits), .intl_bit(intl_bit), .line_dout(line_dout),
      .frame_start(frame_start), .slot_idx(slot_idx)
   );

   typedef struct {
      logic  d;
      logic  fs;
      int    sl;
      string tag;
   } exp_t;

   exp_t       q[$];
   int         checks = 0;
   int         fails  = 0;
   int         n      = 0;
   bit         done   = 0;
   logic       cap_intl, cap_alarm;
   logic [4:0] cap_nat;
   localparam logic [6:0] FAS7 = 7'b0011011;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (n=%0d)", tag, act, exp, n);
      end
   endtask

   task automatic set_idle();
      cap_intl = 1'b1; cap_alarm = 1'b0; cap_nat = 5'b11111;  // R10 idle values
   endtask

   // Driver: called at a negedge, drives one bit, pushes expectation, waits a cycle.
   task automatic drive_cycle(input logic i_b, input logic a_b, input logic [4:0] nb);
      exp_t e;
      int   bp, sl, od;
      logic pay;
      pay = 1'($urandom);
      pay_din = pay; intl_bit = i_b; remote_alarm = a_b; nat_bits = nb;
      bp = n % 8; sl = (n / 8) % 32; od = (n / 256) % 2;
      e.fs = (sl == 0 && bp == 0);
      e.sl = sl;
      if (sl != 0) begin
         e.d = pay; e.tag = (sl == 16) ? "R8 ts16" : "R8";
      end else if (bp == 0) begin
         e.d = cap_intl; e.tag = "R4/R10";
      end else if (od == 0) begin
         e.d = FAS7[7 - bp]; e.tag = "R3/R9";
      end else if (bp == 1) begin
         e.d = 1'b1; e.tag = "R5";
      end else if (bp == 2) begin
         e.d = cap_alarm; e.tag = "R6/R10";
      end else begin
         e.d = cap_nat[7 - bp]; e.tag = "R7/R10";
      end
      q.push_back(e);
      if (sl == 31 && bp == 7) begin
         cap_intl = i_b; cap_alarm = a_b; cap_nat = nb;
      end
      n++;
      @(negedge clk);
   endtask

   // Monitor: pops and compares away from the clock edge.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, int'(line_dout), int'(e.d));
            check("R2", int'(frame_start), int'(e.fs));
            check("R1", int'(slot_idx), e.sl);
         end
      end
   end

   task automatic run_frames(input int first_f, input int count, input int stop_at);
      for (int f = first_f; f < first_f + count; f++) begin
         for (int k = 0; k < 256; k++) begin
            logic       ib, ab;
            logic [4:0] nb;
            if (stop_at >= 0 && n == stop_at) return;
            ib = (f % 3 != 0);
            ab = ((f / 2) % 2 == 1);
            nb = 5'(f * 7) ^ 5'h15;
            // R10: mid-timeslot-0 disturbance that must not reach the line
            if (k >= 1 && k <= 6 && f >= 2) begin
               ib = ~ib; ab = ~ab; nb = ~nb;
            end
            drive_cycle(ib, ab, nb);
         end
      end
   endtask

   task automatic reset_phase(input int cycles);
      rst = 1'b1;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         #2;
         check("R11 strobe", int'(frame_start), 1);
         check("R11 slot", int'(slot_idx), 0);
      end
      @(negedge clk);
      rst = 1'b0;
      n = 0;
      set_idle();
   endtask

   initial begin
      rst = 1'b1; pay_din = 1'b0; intl_bit = 1'b1; remote_alarm = 1'b0; nat_bits = 5'h1f;
      set_idle();
      reset_phase(3);
      run_frames(0, 4, 1000);          // reset lands mid-frame
      reset_phase(2);
      run_frames(4, 8, -1);
      @(negedge clk);
      #3;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule